// File: doc/BRIEF.md
# Serial EEPROM Page-Write Target

This block is the target side of a two-wire serial EEPROM, and it handles write transfers only. A system clock samples the bus clock and data lines through a short synchronizer. The block finds start and stop conditions and checks the device address byte. It then builds a 17-bit word address. The top address bit is carried inside the device address byte. The other sixteen bits follow as two bytes, high byte first.

Each data byte lands in a page buffer at the low part of the word address. Only those low bits advance from byte to byte, so a long burst wraps around inside its own page. A stop after at least one data byte starts an internally timed write cycle. When that cycle ends, every byte held in the page buffer is copied into a behavioural memory array in a single step.

While the cycle runs, the target ignores the bus entirely. A controller can therefore poll for completion: it sends a start and the device address byte, and repeats this until the byte is acknowledged. The data line is driven open-drain through an output enable. A combinational lookup port shows the contents of the array.

Top module: `ee_page_write_slave`

## Requirements
- R1: After reset the data-line enable is low, the busy flag is low and every memory location reads 0.
- R2: The target acknowledges by pulling the data line low for the whole ninth clock after each of these bytes: a matching device address byte, each of the two word-address bytes, and each data byte. The enable changes only while the synchronized clock is low.
- R3: A device address byte matches only when bits 7:4 equal 4'b1010 and bit 0 (the read/write bit) is 0. After any other value the target does not acknowledge that byte and ignores every byte until the next start.
- R4: Bit 1 of the device address byte is word-address bit 16. The high word-address byte gives bits 15:8 and the low byte gives bits 7:0. The array location is the word address modulo MEM_DEPTH.
- R5: A byte write stores its single data byte at the word address once the write cycle ends. The byte write is the device address, two address bytes, one data byte and a stop.
- R6: In a page write, consecutive data bytes go to consecutive word addresses.
- R7: Only the page-offset bits of the address advance. After the last byte of a page the next byte goes to offset 0 of the same page and overwrites what was buffered there. Other pages are left untouched.
- R8: A stop after at least one data byte raises busy for TWR_CYCLES clocks. The array keeps its old contents until busy falls. During the cycle no byte is acknowledged and no bus activity has any effect.
- R9: A device address byte sent while busy is high gets no acknowledge. The same byte sent after busy has fallen is acknowledged.
- R10: A stop that arrives before any data byte does not start a write cycle.
- R11: A start in the middle of a transaction abandons it. Bytes buffered before that start are never written, and the new transaction proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain enable) |
| busy_o | output | 1 | Internal write cycle in progress |
| peek_addr_i | input | 17 | Word address to look up in the array |
| peek_data_o | output | 8 | Array byte at peek_addr_i modulo MEM_DEPTH |

## Verification
The hardest state to reach from the pins is a device address byte arriving while the timed write cycle is still running. The bench reaches it by issuing a poll straight after the stop of a byte write, while the cycle is far from done, and then polling again until the byte is acknowledged. It also sends a complete write transaction during the cycle, one long enough to outlast it, to show that nothing from that transaction reaches the array. The page-wrap case uses a burst of two bytes more than a page, starting two bytes before the page end. This makes the first two offsets be overwritten, and the lookup port then shows the neighbouring pages unchanged.

// File: rtl/ee_pkg.sv
package ee_pkg;
    // 1 bit in the device byte + two address bytes
    localparam int WORD_ADDR_W = 17;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [1:0] {
        K_DEV  = 2'd0,
        K_AHI  = 2'd1,
        K_ALO  = 2'd2,
        K_DATA = 2'd3
    } byte_kind_e;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // stages [SYNC_STAGES-1:0] form the synchronizer, top stage keeps the prior value
    typedef struct packed {
        logic [SYNC_STAGES:0] scl;
        logic [SYNC_STAGES:0] sda;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d     = sy_q;
        sy_d.scl = {sy_q.scl[SYNC_STAGES-1:0], scl_i};
        sy_d.sda = {sy_q.sda[SYNC_STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    logic scl_now, scl_was, sda_now, sda_was;
    assign scl_now = sy_q.scl[SYNC_STAGES-1];
    assign scl_was = sy_q.scl[SYNC_STAGES];
    assign sda_now = sy_q.sda[SYNC_STAGES-1];
    assign sda_was = sy_q.sda[SYNC_STAGES];

    assign scl_lvl   = scl_now;
    assign sda_lvl   = sda_now;
    assign scl_rise  = scl_now & ~scl_was;
    assign scl_fall  = ~scl_now & scl_was;
    assign start_det = scl_now & scl_was & sda_was & ~sda_now;
    assign stop_det  = scl_now & scl_was & ~sda_was & sda_now;
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
    import ee_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int TWR_CYCLES = 500
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              scl_lvl,
    input  logic                              sda_lvl,
    input  logic                              scl_rise,
    input  logic                              scl_fall,
    input  logic                              start_det,
    input  logic                              stop_det,
    output logic                              sda_oe,
    output logic                              busy,
    output logic                              buf_clear,
    output logic                              buf_wr,
    output logic [$clog2(PAGE_BYTES)-1:0]     buf_idx,
    output logic [7:0]                        buf_data,
    output logic                              commit,
    output logic [WORD_ADDR_W-$clog2(PAGE_BYTES)-1:0] row
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int AW = WORD_ADDR_W;
    localparam int TW = $clog2(TWR_CYCLES + 1);

    typedef struct packed {
        byte_kind_e     kind;
        logic           active;
        logic           acking;
        logic [3:0]     bitcnt;
        logic [7:0]     shreg;
        logic [AW-1:0]  addr;
        logic           has_data;
        logic           oe;
        logic           busy;
        logic [TW-1:0]  timer;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d      = st_q;
        buf_clear = 1'b0;
        buf_wr    = 1'b0;
        commit    = 1'b0;
        take      = 1'b0;
        if (st_q.busy) begin
            // timed write cycle: bus is ignored
            if (st_q.timer == TW'(1)) begin
                st_d.busy     = 1'b0;
                st_d.timer    = '0;
                st_d.active   = 1'b0;
                st_d.has_data = 1'b0;
                commit        = 1'b1;
            end else begin
                st_d.timer = st_q.timer - TW'(1);
            end
        end else if (start_det) begin
            st_d.active   = 1'b1;
            st_d.kind     = K_DEV;
            st_d.acking   = 1'b0;
            st_d.bitcnt   = '0;
            st_d.oe       = 1'b0;
            st_d.has_data = 1'b0;
            buf_clear     = 1'b1;
        end else if (stop_det) begin
            st_d.active = 1'b0;
            st_d.acking = 1'b0;
            st_d.oe     = 1'b0;
            if (st_q.active && st_q.has_data) begin
                st_d.busy  = 1'b1;
                st_d.timer = TW'(TWR_CYCLES);
            end
        end else if (st_q.active) begin
            if (st_q.acking) begin
                if (scl_fall) begin
                    st_d.acking = 1'b0;
                    st_d.oe     = 1'b0;
                end
            end else if (scl_rise && st_q.bitcnt != 4'd8) begin
                st_d.shreg  = {st_q.shreg[6:0], sda_lvl};
                st_d.bitcnt = st_q.bitcnt + 4'd1;
            end else if (scl_fall && st_q.bitcnt == 4'd8) begin
                st_d.bitcnt = '0;
                take        = 1'b1;
                case (st_q.kind)
                    K_DEV: begin
                        if (st_q.shreg[7:4] == DEV_CODE && !st_q.shreg[0]) begin
                            st_d.addr[AW-1] = st_q.shreg[1];
                            st_d.kind       = K_AHI;
                        end else begin
                            take        = 1'b0;
                            st_d.active = 1'b0;
                        end
                    end
                    K_AHI: begin
                        st_d.addr[15:8] = st_q.shreg;
                        st_d.kind       = K_ALO;
                    end
                    K_ALO: begin
                        st_d.addr[7:0] = st_q.shreg;
                        st_d.kind      = K_DATA;
                    end
                    default: begin
                        buf_wr               = 1'b1;
                        st_d.addr[PW-1:0]    = st_q.addr[PW-1:0] + PW'(1);
                        st_d.has_data        = 1'b1;
                    end
                endcase
                if (take) begin
                    st_d.acking = 1'b1;
                    st_d.oe     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= K_DEV;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe   = st_q.oe;
    assign busy     = st_q.busy;
    assign buf_idx  = st_q.addr[PW-1:0];
    assign buf_data = st_q.shreg;
    assign row      = st_q.addr[AW-1:PW];

    // R2: acknowledge starts only right after a detected clock fall
    assert_ack_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> $past(scl_fall));
    // R2: the enable never moves while the clock is high
    assert_oe_moves_low_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.oe) |-> !scl_lvl);
    // R8: a write cycle begins only on a stop
    assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(stop_det));
    // R8: the cycle ends with the array commit
    assert_busy_ends_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(commit));
    // R9: no acknowledge while the write cycle runs
    assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !st_q.oe);
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
    parameter int PAGE_BYTES = 256
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear,
    input  logic                               wr_en,
    input  logic [$clog2(PAGE_BYTES)-1:0]      wr_idx,
    input  logic [7:0]                         wr_data,
    output logic [PAGE_BYTES-1:0][7:0]         page_data,
    output logic [PAGE_BYTES-1:0]              page_valid
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      valid;
    } pbuf_t;

    pbuf_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clear) begin
            pb_d.valid = '0;
        end else if (wr_en) begin
            pb_d.data[wr_idx]  = wr_data;
            pb_d.valid[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign page_data  = pb_q.data;
    assign page_valid = pb_q.valid;

    // R6: a received byte is held at its page offset on the next cycle
    assert_buf_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pb_q.valid[$past(wr_idx)] && pb_q.data[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array
    import ee_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int MEM_DEPTH  = 1024
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      commit,
    input  logic [WORD_ADDR_W-$clog2(PAGE_BYTES)-1:0] row,
    input  logic [PAGE_BYTES-1:0][7:0]                page_data,
    input  logic [PAGE_BYTES-1:0]                     page_valid,
    input  logic [WORD_ADDR_W-1:0]                    peek_addr,
    output logic [7:0]                                peek_data
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int MW = $clog2(MEM_DEPTH);
    localparam int AW = WORD_ADDR_W;

    logic [7:0] mem_q [MEM_DEPTH];

    function automatic logic [MW-1:0] fold(input logic [AW-1:0] a);
        return MW'(a % AW'(MEM_DEPTH));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (page_valid[i]) mem_q[fold({row, PW'(i)})] <= page_data[i];
            end
        end
    end

    assign peek_data = mem_q[fold(peek_addr)];
endmodule

// File: rtl/ee_page_write_slave.sv
module ee_page_write_slave
    import ee_pkg::*;
#(
    parameter int PAGE_BYTES  = 256,
    parameter int MEM_DEPTH   = 1024,
    parameter int TWR_CYCLES  = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    output logic                   busy_o,
    input  logic [WORD_ADDR_W-1:0] peek_addr_i,
    output logic [7:0]             peek_data_o
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int RW = WORD_ADDR_W - PW;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic buf_clear, buf_wr, commit;
    logic [PW-1:0] buf_idx;
    logic [7:0] buf_data;
    logic [RW-1:0] row;
    logic [PAGE_BYTES-1:0][7:0] page_data;
    logic [PAGE_BYTES-1:0] page_valid;

    ee_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    ee_ctrl #(.PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_oe(sda_oe_o), .busy(busy_o),
        .buf_clear(buf_clear), .buf_wr(buf_wr), .buf_idx(buf_idx),
        .buf_data(buf_data), .commit(commit), .row(row)
    );

    ee_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(buf_wr),
        .wr_idx(buf_idx), .wr_data(buf_data),
        .page_data(page_data), .page_valid(page_valid)
    );

    ee_mem_array #(.PAGE_BYTES(PAGE_BYTES), .MEM_DEPTH(MEM_DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .commit(commit), .row(row),
        .page_data(page_data), .page_valid(page_valid),
        .peek_addr(peek_addr_i), .peek_data(peek_data_o)
    );
endmodule

// File: tb/sim_ee_page_write_slave.sv
module sim_ee_page_write_slave;
    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        oe, busy;
    logic [16:0] peek_addr = '0;
    logic [7:0]  peek_data;
    logic        sda_line;

    assign sda_line = sda_m & ~oe;

    always #5 clk = ~clk;

    ee_page_write_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(oe), .busy_o(busy), .peek_addr_i(peek_addr),
        .peek_data_o(peek_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] wbuf [512];
    logic [7:0] exp_mem [1024];

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(Q);
            scl_m = 1'b1; wclk(2 * Q);
            scl_m = 1'b0; wclk(Q);
        end
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        ack = (sda_line === 1'b0);
        wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    function automatic logic [7:0] dev_w(input logic [16:0] a);
        return {4'b1010, 2'b00, a[16], 1'b0};
    endfunction

    task automatic send_write(input logic [16:0] a, input int n, output int acks);
        logic ack;
        acks = 0;
        bus_start();
        bus_byte(dev_w(a), ack); acks += int'(ack);
        bus_byte(a[15:8], ack);  acks += int'(ack);
        bus_byte(a[7:0], ack);   acks += int'(ack);
        for (int j = 0; j < n; j++) begin
            bus_byte(wbuf[j], ack); acks += int'(ack);
        end
    endtask

    task automatic commit_model(input logic [16:0] a, input int n);
        for (int j = 0; j < n; j++) begin
            logic [7:0] off;
            off = a[7:0] + 8'(j);
            exp_mem[{a[9:8], off}] = wbuf[j];
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 2000) begin wclk(1); k++; end
        wclk(2);
    endtask

    task automatic chk_mem(input string tag, input logic [16:0] a);
        peek_addr = a; wclk(1);
        chk(tag, {24'd0, peek_data}, {24'd0, exp_mem[a[9:0]]});
    endtask

    task automatic t_reset();
        chk("R1 oe in reset", {31'd0, oe}, 0);
        chk("R1 busy in reset", {31'd0, busy}, 0);
        wclk(3); rst_n = 1'b1; wclk(3);
        chk("R1 oe after reset", {31'd0, oe}, 0);
        chk("R1 busy after reset", {31'd0, busy}, 0);
        chk_mem("R1 mem 0x000", 17'h00000);
        chk_mem("R1 mem 0x3ff", 17'h003ff);
    endtask

    task automatic t_byte_write_poll();
        int acks; logic ack; int tries; logic got;
        wbuf[0] = 8'h5A;
        send_write(17'h00123, 1, acks);
        chk("R2 acks on byte write", acks, 4);
        bus_stop();
        chk("R8 busy after stop", {31'd0, busy}, 1);
        chk_mem("R8 array unchanged while busy", 17'h00123);
        bus_start(); bus_byte(8'hA0, ack); bus_stop();
        chk("R9 poll while busy gets no ack", {31'd0, ack}, 0);
        got = 1'b0; tries = 0;
        while (!got && tries < 8) begin
            bus_start(); bus_byte(8'hA0, ack);
            if (ack) begin
                got = 1'b1;
                chk("R9 busy low when poll acked", {31'd0, busy}, 0);
            end
            bus_stop(); tries++;
        end
        chk("R9 poll eventually acked", {31'd0, got}, 1);
        wclk(4);
        chk("R10 stop after poll starts no cycle", {31'd0, busy}, 0);
        commit_model(17'h00123, 1);
        chk_mem("R5 byte write stored", 17'h00123);
    endtask

    task automatic t_bad_addr();
        logic ack;
        bus_start();
        bus_byte(8'hB0, ack);
        chk("R3 wrong code not acked", {31'd0, ack}, 0);
        bus_byte(8'h01, ack);
        chk("R3 later byte ignored", {31'd0, ack}, 0);
        bus_byte(8'h33, ack);
        bus_stop(); wclk(4);
        chk("R3 no write cycle", {31'd0, busy}, 0);
        bus_start();
        bus_byte(8'hA1, ack);
        chk("R3 read bit not acked", {31'd0, ack}, 0);
        bus_stop();
    endtask

    task automatic t_top_bit();
        int acks;
        wbuf[0] = 8'hC3;
        send_write(17'h10205, 1, acks);
        chk("R4 acks with bit16 set", acks, 4);
        bus_stop(); wait_idle();
        commit_model(17'h10205, 1);
        chk_mem("R4 folded location", 17'h10205);
    endtask

    task automatic t_page();
        int acks;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        send_write(17'h00110, 4, acks);
        chk("R2 acks on page write", acks, 7);
        bus_stop(); wait_idle();
        commit_model(17'h00110, 4);
        chk_mem("R6 byte 0", 17'h00110);
        chk_mem("R6 byte 1", 17'h00111);
        chk_mem("R6 byte 3", 17'h00113);
        chk_mem("R6 next untouched", 17'h00114);
    endtask

    task automatic t_wrap();
        int acks;
        for (int j = 0; j < 258; j++) wbuf[j] = 8'(j) ^ 8'h5A;
        send_write(17'h002FE, 258, acks);
        chk("R7 all bytes acked", acks, 261);
        bus_stop(); wait_idle();
        commit_model(17'h002FE, 258);
        chk_mem("R7 offset FE overwritten", 17'h002FE);
        chk_mem("R7 offset FF overwritten", 17'h002FF);
        chk_mem("R7 offset 00 after wrap", 17'h00200);
        chk_mem("R7 offset 7F", 17'h0027F);
        chk_mem("R7 offset FD", 17'h002FD);
        chk_mem("R7 next page untouched", 17'h00300);
        chk_mem("R7 previous page untouched", 17'h001FF);
    endtask

    task automatic t_early_stop();
        int acks;
        send_write(17'h00380, 0, acks);
        chk("R10 address bytes acked", acks, 3);
        bus_stop(); wclk(4);
        chk("R10 no write cycle", {31'd0, busy}, 0);
        chk_mem("R10 array unchanged", 17'h00380);
    endtask

    task automatic t_restart();
        int acks;
        wbuf[0] = 8'h77;
        send_write(17'h00050, 1, acks);
        wbuf[0] = 8'h88;
        send_write(17'h00060, 1, acks);
        chk("R11 new transaction acked", acks, 4);
        bus_stop(); wait_idle();
        commit_model(17'h00060, 1);
        chk_mem("R11 abandoned byte not written", 17'h00050);
        chk_mem("R11 new byte written", 17'h00060);
    endtask

    task automatic t_busy_ignore();
        int acks; logic ack;
        wbuf[0] = 8'h99;
        send_write(17'h00070, 1, acks);
        bus_stop();
        chk("R8 busy raised", {31'd0, busy}, 1);
        bus_start();
        bus_byte(dev_w(17'h00071), ack);
        chk("R8 device byte ignored while busy", {31'd0, ack}, 0);
        bus_byte(8'h00, ack);
        bus_byte(8'h71, ack);
        bus_byte(8'h42, ack);
        bus_stop();
        wait_idle();
        chk("R8 ignored transaction starts no cycle", {31'd0, busy}, 0);
        commit_model(17'h00070, 1);
        chk_mem("R8 first write kept", 17'h00070);
        chk_mem("R8 ignored data not stored", 17'h00071);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
        t_reset();
        t_byte_write_poll();
        t_bad_addr();
        t_top_bit();
        t_page();
        t_early_stop();
        t_wrap();
        t_restart();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule